// File: doc/BRIEF.md
# Staggered Half-Word Integer ALU

This block is a 32-bit integer ALU for the fast clock domain of an execution core. It splits each result into three steps on three consecutive clock edges. The 16-bit low half is computed in the issue cycle. The 16-bit high half is computed in the next cycle, using the carry that the low half left in a register. The four condition flags are computed in the cycle after that. The block accepts one operation per cycle. A dependent operation can issue in the cycle right after its producer, because its low half only needs the producer's low half, and that half is already available. Its high half then meets the producer's high half one cycle later.

Each operand is chosen by its own 4-way bypass select. The four sources are:
- this ALU's own previous result;
- the staggered result of a neighbouring ALU;
- returning load data;
- a word from a slower bypass network, registered one cycle before use.

The operation set covers add and subtract (subtract inverts operand B), four bitwise logic functions, and byte or half-word sign extension. A carry-block input cuts the carry chain at every byte boundary, so four independent 8-bit adds or subtracts can run at once. The low half of each result also leaves the block early on its own port, where it can serve as an address input.

The pipeline has three named stages:
- LOW: the issue cycle.
- HIGH: issue + 1.
- FLAG: issue + 2.

Each stage's valid bit moves to the next stage on every clock edge. There are no other states and no stalls.

Top module: `staggered_alu`

## Requirements
- R1: While reset is held, every valid output is 0 and the early half, the result and all flags are 0.
- R2: For an operation issued with `in_vld`=1, the low 16 bits appear on `early_lo` with `early_vld`=1 one cycle after issue. The full 32-bit result appears on `res` with `res_vld`=1 two cycles after issue, and its low half equals the earlier `early_lo`.
- R3: The high half uses the carry-out of the low half, registered between the two stages. Example: 0x0000FFFF + 1 = 0x00010000.
- R4: The flags `flg_c`, `flg_z`, `flg_n` and `flg_v` appear with `flg_vld`=1 three cycles after issue.
- R5: For op code 1 (subtract), the result is A + ~B + 1. The carry flag is the carry-out of bit 31, so it is 1 when no borrow occurred.
- R6: When `in_blk`=1, no carry crosses a byte boundary. Each byte's carry-in is 0 for add (op 0) and 1 for subtract (op 1).
- R7: Op codes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and NOT(A OR B). For these, carry and overflow are 0.
- R8: Op code 6 sign-extends A[7:0] and op code 7 sign-extends A[15:0] to 32 bits. Operand B has no effect on either. Carry and overflow are 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0, including bits from both halves. The sign flag is bit 31. For add and subtract, overflow is set when A and the possibly inverted B have equal bit 31 and the result's bit 31 differs from it.
- R10: Select codes for `in_sela` and `in_selb` are:
  - 0: this ALU's result from the previous issue slot, so dependent operations can issue back to back.
  - 1: the neighbour's result, with its low half on `peer_lo` in the issue cycle and its high half on `peer_hi` one cycle later.
  - 2: `ld_data` in the issue cycle.
  - 3: the word on `late_data` one cycle before issue.
- R11: A new operation is accepted on every cycle. A cycle with `in_vld`=0 produces no valid output at any stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Issue an operation this cycle |
| in_op | input | 3 | Operation code (R5 to R8) |
| in_sela | input | 2 | Bypass select for operand A (R10) |
| in_selb | input | 2 | Bypass select for operand B (R10) |
| in_blk | input | 1 | Block carries at byte boundaries |
| peer_lo | input | 16 | Neighbour ALU low half, in the issue cycle |
| peer_hi | input | 16 | Neighbour ALU high half, one cycle later |
| ld_data | input | 32 | Load return data |
| late_data | input | 32 | Slow bypass word, one cycle before issue |
| early_vld | output | 1 | `early_lo` is valid |
| early_lo | output | 16 | Low result half, one cycle after issue |
| res_vld | output | 1 | `res` is valid |
| res | output | 32 | Full result, two cycles after issue |
| flg_vld | output | 1 | Flags are valid |
| flg_c | output | 1 | Carry out of bit 31 |
| flg_z | output | 1 | Result is zero |
| flg_n | output | 1 | Result bit 31 |
| flg_v | output | 1 | Signed overflow |

## Verification
The assertions check the following on every cycle:
- a valid bit moves from the LOW stage to HIGH and from HIGH to FLAG;
- the full result's low half matches what `early_lo` showed one cycle before;
- the zero and sign flags match the result they were formed from;
- logic and sign-extension operations leave carry and overflow clear.

Only the bench's scenarios can show that the results themselves are correct. These scenarios cover the carry crossing from bit 15 into bit 16, byte-blocked packed arithmetic, and dependent chains issued back to back through the own-result bypass. They also cover the one-cycle stagger of the neighbour and slow-bypass sources, which requires a reference model that tracks what each source held in which cycle.

// File: rtl/salu_pkg.sv
package salu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NOR  = 3'd5,
        OP_SEXB = 3'd6,
        OP_SEXH = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_OWN  = 2'd0,
        SRC_PEER = 2'd1,
        SRC_LOAD = 2'd2,
        SRC_LATE = 2'd3
    } byp_sel_e;

    // Control that travels beside the data from one stage to the next
    typedef struct packed {
        logic     vld;
        alu_op_e  op;
        byp_sel_e sa;
        byp_sel_e sb;
        logic     blk;
    } stage_ctl_t;

endpackage

// File: rtl/salu_bypass.sv
module salu_bypass
    import salu_pkg::*;
#(
    parameter int W = 16
) (
    input  byp_sel_e       sel,
    input  logic [W-1:0]   own,
    input  logic [W-1:0]   peer,
    input  logic [W-1:0]   load,
    input  logic [W-1:0]   late,
    output logic [W-1:0]   y
);

    // First-level operand mux: exactly four sources
    always_comb begin
        unique case (sel)
            SRC_OWN:  y = own;
            SRC_PEER: y = peer;
            SRC_LOAD: y = load;
            SRC_LATE: y = late;
        endcase
    end

endmodule

// File: rtl/salu_slice.sv
module salu_slice
    import salu_pkg::*;
#(
    parameter int SW = 16
) (
    input  alu_op_e        op,
    input  logic           blk,
    input  logic [SW-1:0]  a,
    input  logic [SW-1:0]  b,
    input  logic           cin,
    input  logic [SW-1:0]  sext_val,
    output logic [SW-1:0]  r,
    output logic           cout
);

    localparam int BW = 8;
    localparam int NB = SW / BW;

    logic          sub;
    logic [SW-1:0] bx;
    logic [SW-1:0] sum;
    logic [NB:0]   cc;

    assign sub   = (op == OP_SUB);
    assign bx    = sub ? ~b : b;
    assign cc[0] = cin;

    // One byte adder per byte; the carry between bytes can be cut
    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic        cin_k;
        logic [BW:0] s9;
        if (k == 0) begin : g_first
            assign cin_k = cc[0];
        end else begin : g_rest
            assign cin_k = blk ? sub : cc[k];
        end
        assign s9 = {1'b0, a[k*BW +: BW]} + {1'b0, bx[k*BW +: BW]} + {{BW{1'b0}}, cin_k};
        assign sum[k*BW +: BW] = s9[BW-1:0];
        assign cc[k+1]         = s9[BW];
    end

    assign cout = cc[NB];

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:   r = sum;
            OP_AND:           r = a & b;
            OP_OR:            r = a | b;
            OP_XOR:           r = a ^ b;
            OP_NOR:           r = ~(a | b);
            OP_SEXB, OP_SEXH: r = sext_val;
        endcase
    end

endmodule

// File: rtl/salu_flags.sv
module salu_flags
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  res,
    input  logic          cout,
    input  logic          ovf,
    output logic          fc,
    output logic          fz,
    output logic          fn,
    output logic          fv
);

    logic arith;

    assign arith = (op == OP_ADD) || (op == OP_SUB);
    assign fc    = arith & cout;
    assign fv    = arith & ovf;
    assign fz    = (res == '0);
    assign fn    = res[W-1];

endmodule

// File: rtl/staggered_alu.sv
module staggered_alu
    import salu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [2:0]          in_op,
    input  logic [1:0]          in_sela,
    input  logic [1:0]          in_selb,
    input  logic                in_blk,
    input  logic [DATA_W/2-1:0] peer_lo,
    input  logic [DATA_W/2-1:0] peer_hi,
    input  logic [DATA_W-1:0]   ld_data,
    input  logic [DATA_W-1:0]   late_data,
    output logic                early_vld,
    output logic [DATA_W/2-1:0] early_lo,
    output logic                res_vld,
    output logic [DATA_W-1:0]   res,
    output logic                flg_vld,
    output logic                flg_c,
    output logic                flg_z,
    output logic                flg_n,
    output logic                flg_v
);

    localparam int HALF   = DATA_W / 2;
    localparam int BYTE_W = 8;

    // Stage registers
    stage_ctl_t        ctl0, ctl1;
    logic [HALF-1:0]   lo_q, lo2_q, hi_q;
    logic [HALF-1:0]   ld_hi_q, late_hi_q;
    logic [DATA_W-1:0] late_q;
    logic              c_lo_q, sx_q;
    logic              vld2, c2_q, v2_q, vld3;
    alu_op_e           op2;
    logic              fc_d, fz_d, fn_d, fv_d;

    assign ctl0 = '{vld: in_vld, op: alu_op_e'(in_op), sa: byp_sel_e'(in_sela),
                    sb: byp_sel_e'(in_selb), blk: in_blk};

    // ---------------- LOW stage (issue cycle) ----------------
    logic [HALF-1:0] a_lo, b_lo, r_lo, sext_lo;
    logic            c_lo;

    salu_bypass #(.W(HALF)) u_byp_alo (
        .sel(ctl0.sa), .own(lo_q), .peer(peer_lo),
        .load(ld_data[HALF-1:0]), .late(late_q[HALF-1:0]), .y(a_lo));
    salu_bypass #(.W(HALF)) u_byp_blo (
        .sel(ctl0.sb), .own(lo_q), .peer(peer_lo),
        .load(ld_data[HALF-1:0]), .late(late_q[HALF-1:0]), .y(b_lo));

    assign sext_lo = (ctl0.op == OP_SEXB)
                   ? {{(HALF-BYTE_W){a_lo[BYTE_W-1]}}, a_lo[BYTE_W-1:0]}
                   : a_lo;

    salu_slice #(.SW(HALF)) u_lo (
        .op(ctl0.op), .blk(ctl0.blk), .a(a_lo), .b(b_lo),
        .cin(ctl0.op == OP_SUB), .sext_val(sext_lo), .r(r_lo), .cout(c_lo));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1      <= '0;
            lo_q      <= '0;
            c_lo_q    <= 1'b0;
            sx_q      <= 1'b0;
            ld_hi_q   <= '0;
            late_q    <= '0;
            late_hi_q <= '0;
        end else begin
            ctl1      <= ctl0;
            lo_q      <= r_lo;
            c_lo_q    <= c_lo;
            sx_q      <= sext_lo[HALF-1];
            ld_hi_q   <= ld_data[DATA_W-1:HALF];
            late_q    <= late_data;
            late_hi_q <= late_q[DATA_W-1:HALF];
        end
    end

    // ---------------- HIGH stage (issue + 1) ----------------
    logic [HALF-1:0] a_hi, b_hi, r_hi, bx_hi;
    logic            c_hi, cin_hi, v_hi;

    salu_bypass #(.W(HALF)) u_byp_ahi (
        .sel(ctl1.sa), .own(hi_q), .peer(peer_hi),
        .load(ld_hi_q), .late(late_hi_q), .y(a_hi));
    salu_bypass #(.W(HALF)) u_byp_bhi (
        .sel(ctl1.sb), .own(hi_q), .peer(peer_hi),
        .load(ld_hi_q), .late(late_hi_q), .y(b_hi));

    assign cin_hi = ctl1.blk ? (ctl1.op == OP_SUB) : c_lo_q;

    salu_slice #(.SW(HALF)) u_hi (
        .op(ctl1.op), .blk(ctl1.blk), .a(a_hi), .b(b_hi),
        .cin(cin_hi), .sext_val({HALF{sx_q}}), .r(r_hi), .cout(c_hi));

    assign bx_hi = (ctl1.op == OP_SUB) ? ~b_hi : b_hi;
    assign v_hi  = (a_hi[HALF-1] == bx_hi[HALF-1]) && (r_hi[HALF-1] != a_hi[HALF-1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld2  <= 1'b0;
            op2   <= OP_ADD;
            hi_q  <= '0;
            lo2_q <= '0;
            c2_q  <= 1'b0;
            v2_q  <= 1'b0;
        end else begin
            vld2  <= ctl1.vld;
            op2   <= ctl1.op;
            hi_q  <= r_hi;
            lo2_q <= lo_q;
            c2_q  <= c_hi;
            v2_q  <= v_hi;
        end
    end

    // ---------------- FLAG stage (issue + 2) ----------------
    salu_flags #(.W(DATA_W)) u_flags (
        .op(op2), .res({hi_q, lo2_q}), .cout(c2_q), .ovf(v2_q),
        .fc(fc_d), .fz(fz_d), .fn(fn_d), .fv(fv_d));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld3  <= 1'b0;
            flg_c <= 1'b0;
            flg_z <= 1'b0;
            flg_n <= 1'b0;
            flg_v <= 1'b0;
        end else begin
            vld3  <= vld2;
            flg_c <= fc_d;
            flg_z <= fz_d;
            flg_n <= fn_d;
            flg_v <= fv_d;
        end
    end

    assign early_vld = ctl1.vld;
    assign early_lo  = lo_q;
    assign res_vld   = vld2;
    assign res       = {hi_q, lo2_q};
    assign flg_vld   = vld3;

    // ---------------- Assertions ----------------
    a_r2_early_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> early_vld);

    a_r2_result_after_early: assert property (@(posedge clk) disable iff (!rst_n)
        early_vld |=> res_vld);

    a_r2_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        early_vld |=> (res[HALF-1:0] == $past(early_lo)));

    a_r4_flags_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> flg_vld);

    a_r9_zero_from_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
        flg_vld |-> (flg_z == ($past(res) == '0)));

    a_r9_sign_from_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        flg_vld |-> (flg_n == $past(res[DATA_W-1])));

    a_r7_nonarith_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && (op2 inside {OP_AND, OP_OR, OP_XOR, OP_NOR, OP_SEXB, OP_SEXH}))
        |=> (!flg_c && !flg_v));

endmodule

// File: tb/tb_staggered_alu.sv
`timescale 1ns/1ps
module tb_staggered_alu;

    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld, in_blk;
    logic [2:0]  in_op;
    logic [1:0]  in_sela, in_selb;
    logic [15:0] peer_lo, peer_hi;
    logic [31:0] ld_data, late_data;
    logic        early_vld, res_vld, flg_vld;
    logic [15:0] early_lo;
    logic [31:0] res;
    logic        flg_c, flg_z, flg_n, flg_v;

    always #2 clk = ~clk;   // 250 MHz

    staggered_alu dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_sela(in_sela), .in_selb(in_selb), .in_blk(in_blk),
        .peer_lo(peer_lo), .peer_hi(peer_hi), .ld_data(ld_data),
        .late_data(late_data), .early_vld(early_vld), .early_lo(early_lo),
        .res_vld(res_vld), .res(res), .flg_vld(flg_vld), .flg_c(flg_c),
        .flg_z(flg_z), .flg_n(flg_n), .flg_v(flg_v));

    // Scenario table and reference results
    logic        t_vld [N];
    logic [2:0]  t_op  [N];
    logic [1:0]  t_sa  [N];
    logic [1:0]  t_sb  [N];
    logic        t_blk [N];
    logic [31:0] t_ld  [N];
    logic [31:0] t_late[N];
    logic [31:0] t_peer[N];
    string       t_tag [N];
    logic [31:0] e_res [N];
    logic [3:0]  e_flg [N];

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put(input int c, input logic [2:0] op, input logic [1:0] sa, input logic [1:0] sb,
                       input logic blk, input logic [31:0] ld, input logic [31:0] lt,
                       input logic [31:0] pr, input string tag);
        t_vld[c] = 1'b1; t_op[c] = op; t_sa[c] = sa; t_sb[c] = sb; t_blk[c] = blk;
        t_ld[c] = ld; t_late[c] = lt; t_peer[c] = pr; t_tag[c] = tag;
    endtask

    // Behavioural reference: returns {c, z, n, v, result}
    function automatic logic [35:0] ref_alu(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic blk);
        logic [31:0] r, bb;
        logic        c, v, sub;
        int          s;
        sub = (op == 3'd1);
        bb  = sub ? ~b : b;
        c   = sub;
        v   = 1'b0;
        r   = '0;
        case (op)
            3'd0, 3'd1: begin
                for (int k = 0; k < 4; k++) begin
                    s = int'(a[8*k +: 8]) + int'(bb[8*k +: 8]) + ((blk && k > 0) ? int'(sub) : int'(c));
                    r[8*k +: 8] = s[7:0];
                    c = (s > 255);
                end
                v = (a[31] == bb[31]) && (r[31] != a[31]);
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = ~(a | b);
            3'd6: r = {{24{a[7]}}, a[7:0]};
            default: r = {{16{a[15]}}, a[15:0]};
        endcase
        if (op > 3'd1) begin
            c = 1'b0;
            v = 1'b0;
        end
        return {c, (r == 32'd0), r[31], v, r};
    endfunction

    function automatic logic [31:0] opnd(input int c, input logic [1:0] s);
        case (s)
            2'd0:    return (c > 0) ? e_res[c-1] : 32'd0;
            2'd1:    return t_peer[c];
            2'd2:    return t_ld[c];
            default: return t_late[c];
        endcase
    endfunction

    task automatic build();
        logic [31:0] lf;
        logic [35:0] o;
        lf = 32'h1ACE_B00C;
        for (int c = 0; c < N; c++) begin
            t_vld[c] = 1'b0; t_op[c] = '0; t_sa[c] = 2'd2; t_sb[c] = 2'd2; t_blk[c] = 1'b0;
            t_ld[c] = '0; t_late[c] = '0; t_peer[c] = '0; t_tag[c] = "R11";
        end
        put(0,  3'd0, 2'd2, 2'd3, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h0, "R3");
        put(1,  3'd1, 2'd2, 2'd3, 1'b0, 32'h00000005, 32'h00000007, 32'h0, "R5");
        put(2,  3'd1, 2'd2, 2'd3, 1'b0, 32'h00000007, 32'h00000005, 32'h0, "R5");
        put(3,  3'd0, 2'd2, 2'd3, 1'b1, 32'h80FF7FFF, 32'h80010101, 32'h0, "R6");
        put(4,  3'd1, 2'd2, 2'd3, 1'b1, 32'h00010203, 32'h01010101, 32'h0, "R6");
        // slot 5 left empty: bubble, R11
        put(6,  3'd2, 2'd2, 2'd1, 1'b0, 32'hF0F01234, 32'h0, 32'hFF00FF00, "R7");
        put(7,  3'd3, 2'd2, 2'd1, 1'b0, 32'hF0F01234, 32'h0, 32'h0F0F0001, "R7");
        put(8,  3'd4, 2'd2, 2'd3, 1'b0, 32'hFFFF0000, 32'h0FF00FF0, 32'h0, "R7");
        put(9,  3'd5, 2'd2, 2'd3, 1'b0, 32'h00FF00FF, 32'h0F0F0F0F, 32'h0, "R7");
        put(10, 3'd6, 2'd2, 2'd3, 1'b0, 32'h00000080, 32'hFFFFFFFF, 32'h0, "R8");
        put(11, 3'd7, 2'd2, 2'd3, 1'b0, 32'h12348001, 32'h5555AAAA, 32'h0, "R8");
        put(12, 3'd6, 2'd2, 2'd3, 1'b0, 32'hABCDEF7F, 32'hFFFFFFFF, 32'h0, "R8");
        put(13, 3'd0, 2'd2, 2'd3, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h0, "R9");
        put(14, 3'd1, 2'd2, 2'd3, 1'b0, 32'h12345678, 32'h12345678, 32'h0, "R9");
        put(15, 3'd0, 2'd2, 2'd3, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h0, "R9");
        put(16, 3'd0, 2'd2, 2'd3, 1'b0, 32'h00000001, 32'h00000001, 32'h0, "R10");
        for (int c = 17; c < 22; c++)
            put(c, 3'd0, 2'd0, 2'd2, 1'b0, 32'h00008001, 32'h0, 32'h0, "R10");
        put(22, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 32'h0, 32'h0, "R10");
        // slot 23 bubble
        put(24, 3'd0, 2'd1, 2'd3, 1'b0, 32'h0, 32'h0000F000, 32'h1234F000, "R10");
        put(25, 3'd1, 2'd3, 2'd1, 1'b0, 32'h0, 32'h9ABC0000, 32'h00010001, "R10");
        for (int c = 26; c < N; c++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            t_vld[c]  = (lf[3:0] != 4'd0);
            t_op[c]   = lf[6:4];
            t_sa[c]   = (lf[8:7] == 2'd0 && !t_vld[c-1]) ? 2'd2 : lf[8:7];
            t_sb[c]   = (lf[10:9] == 2'd0 && !t_vld[c-1]) ? 2'd3 : lf[10:9];
            t_blk[c]  = lf[11];
            t_ld[c]   = lf ^ 32'h5A5A_1234;
            t_late[c] = {lf[15:0], lf[31:16]};
            t_peer[c] = ~lf;
            t_tag[c]  = "R11";
        end
        for (int c = 0; c < N; c++) begin
            o = ref_alu(t_op[c], opnd(c, t_sa[c]), opnd(c, t_sb[c]), t_blk[c]);
            e_res[c] = o[31:0];
            e_flg[c] = o[35:32];
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        build();
        rst_n = 1'b0; in_vld = 1'b0; in_op = '0; in_sela = '0; in_selb = '0; in_blk = 1'b0;
        peer_lo = '0; peer_hi = '0; ld_data = '0; late_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!early_vld && !res_vld && !flg_vld, "R1 valids", {29'd0, early_vld, res_vld, flg_vld}, 32'd0);
        check(res == 32'd0 && early_lo == 16'd0, "R1 data", res | {16'd0, early_lo}, 32'd0);
        check({flg_c, flg_z, flg_n, flg_v} == 4'd0, "R1 flags", {28'd0, flg_c, flg_z, flg_n, flg_v}, 32'd0);
        rst_n = 1'b1;
        late_data = t_late[0];
        for (int i = 0; i <= N + 3; i++) begin
            @(negedge clk);
            begin
                int  j;
                logic ev;
                j  = i - 1;
                ev = (j >= 0 && j < N) ? t_vld[j] : 1'b0;
                check(early_vld == ev, "R11 early_vld", {31'd0, early_vld}, {31'd0, ev});
                if (ev) check(early_lo == e_res[j][15:0], {"R2 early_lo ", t_tag[j]},
                              {16'd0, early_lo}, {16'd0, e_res[j][15:0]});
                j  = i - 2;
                ev = (j >= 0 && j < N) ? t_vld[j] : 1'b0;
                check(res_vld == ev, "R11 res_vld", {31'd0, res_vld}, {31'd0, ev});
                if (ev) check(res == e_res[j], {"R2 res ", t_tag[j]}, res, e_res[j]);
                j  = i - 3;
                ev = (j >= 0 && j < N) ? t_vld[j] : 1'b0;
                check(flg_vld == ev, "R4 flg_vld", {31'd0, flg_vld}, {31'd0, ev});
                if (ev) check({flg_c, flg_z, flg_n, flg_v} == e_flg[j], {"R4 flags ", t_tag[j]},
                              {28'd0, flg_c, flg_z, flg_n, flg_v}, {28'd0, e_flg[j]});
            end
            if (i < N) begin
                in_vld = t_vld[i]; in_op = t_op[i]; in_sela = t_sa[i]; in_selb = t_sb[i];
                in_blk = t_blk[i]; ld_data = t_ld[i]; peer_lo = t_peer[i][15:0];
            end else begin
                in_vld = 1'b0; in_op = '0; in_sela = '0; in_selb = '0;
                in_blk = 1'b0; ld_data = '0; peer_lo = '0;
            end
            late_data = (i + 1 < N) ? t_late[i+1] : 32'd0;
            peer_hi   = (i >= 1 && i - 1 < N) ? t_peer[i-1][31:16] : 16'd0;
        end
        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule